// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Tracker

This block watches the clock-enable pin of one DDR3-style memory device, together with a decoded command and a single "some bank is open" status bit. On every rising clock edge it compares the clock-enable level at that edge with the level at the edge before. From that pair, the command and the bank status, it decides the device's power state. The four states are normal operation, active power-down, precharge power-down and self refresh.

Each combination that the power-state rules do not allow is reported as illegal. The block also enforces the minimum clock-enable hold: after any transition, the new level must be registered at a set number of consecutive edges before it may change again. The tracker sits beside a memory controller or a device model. It reports the current power state and a one-cycle error pulse, so that protocol mistakes show up at the edge that caused them.

Top module: `cke_power_tracker`

## Requirements
- R1: A synchronous active-high reset puts the tracker in normal state (powerState 2'b00) with errPulse low. The previous clock-enable level is taken as high, and the minimum hold counts as already met.
- R2: In any power-down or self-refresh state, clock-enable low at both the previous and the current edge keeps the state unchanged with no error, whatever the command.
- R3: In any power-down or self-refresh state, a low-to-high clock-enable transition with deselect (cmdIn 3'd0) or no-operation (cmdIn 3'd1) returns the state to normal (2'b00).
- R4: In normal state with bankOpen high, a high-to-low transition with deselect or no-operation enters active power-down (2'b01).
- R5: In normal state with bankOpen low, a high-to-low transition with deselect or no-operation enters precharge power-down (2'b10).
- R6: In normal state with bankOpen low, a high-to-low transition with a refresh command (cmdIn 3'd2) enters self refresh (2'b11).
- R7: Every other combination of state, clock-enable pair and command is illegal. This covers a falling edge with any other command, a refresh while a bank is open, a rising edge in a low-power state with any command other than deselect or no-operation, and a clock-enable pair that does not fit the state. An illegal combination raises errPulse and leaves the state unchanged.
- R8: A clock-enable transition raises errPulse when the previous level was registered at fewer than MIN_HOLD consecutive edges (default 3). The state change that the transition implies still takes place. A transition after exactly MIN_HOLD edges is legal.
- R9: In normal state with clock-enable high at both edges, the state stays normal with no error, for any command and any bank status.
- R10: powerState and errPulse are registered and reflect the edge just taken. errPulse is high for exactly one cycle per faulty edge and low after an edge without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ckeIn | input | 1 | Clock-enable level sampled at this edge |
| cmdIn | input | 3 | Decoded command: 0 deselect, 1 no-operation, 2 refresh, 3..7 any other command |
| bankOpen | input | 1 | High when at least one bank is active |
| powerState | output | 2 | 00 normal, 01 active power-down, 10 precharge power-down, 11 self refresh |
| errPulse | output | 1 | One-cycle flag for an illegal combination or a short clock-enable hold |

## Verification
Both results are registered once. The state decided from the inputs present at edge n, and any error flag for that edge, can be read just after edge n. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Each check therefore covers precisely one registered edge. The hold-time checks count edges from the transition edge itself, which is registration number one. A violation is expected at the second edge of a new level, and the boundary case, falling again after the third edge, is expected to be clean.

// File: rtl/cke_track_pkg.sv
package cke_track_pkg;

  typedef enum logic [1:0] {
    PWR_NORMAL   = 2'b00,
    PWR_ACT_DOWN = 2'b01,
    PWR_PRE_DOWN = 2'b10,
    PWR_SELF_REF = 2'b11
  } pwrState_t;

  localparam logic [2:0] CMD_DESELECT = 3'd0;
  localparam logic [2:0] CMD_NOP      = 3'd1;
  localparam logic [2:0] CMD_REFRESH  = 3'd2;

  // Clock-enable observations handed from the datapath to the control
  typedef struct packed {
    logic prevLvl;
    logic curLvl;
    logic holdShort;
  } ckeEdge_t;

  // Strobes from the control back to the datapath
  typedef struct packed {
    logic raiseErr;
  } ctrlStrobe_t;

endpackage

// File: rtl/cke_edge_path.sv
module cke_edge_path
  import cke_track_pkg::*;
#(
  parameter int MIN_HOLD = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ckeIn,
  input  ctrlStrobe_t strobe,
  output ckeEdge_t    edgeInfo,
  output logic        errPulse
);

  localparam int CNT_W = $clog2(MIN_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_FULL = CNT_W'(MIN_HOLD);
  localparam logic [CNT_W-1:0] HOLD_ONE  = CNT_W'(1);

  logic             ckePrevQ;
  logic [CNT_W-1:0] holdCntQ;
  logic             errQ;
  logic             toggle;

  assign toggle = ckeIn ^ ckePrevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ckePrevQ <= 1'b1;
      holdCntQ <= HOLD_FULL;
      errQ     <= 1'b0;
    end else begin
      ckePrevQ <= ckeIn;
      if (toggle) begin
        holdCntQ <= HOLD_ONE;
      end else if (holdCntQ < HOLD_FULL) begin
        holdCntQ <= holdCntQ + HOLD_ONE;
      end
      errQ <= strobe.raiseErr;
    end
  end

  always_comb begin
    edgeInfo.prevLvl   = ckePrevQ;
    edgeInfo.curLvl    = ckeIn;
    edgeInfo.holdShort = toggle && (holdCntQ < HOLD_FULL);
  end

  assign errPulse = errQ;

  AST_SHORT_HOLD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    ((ckeIn != ckePrevQ) && (holdCntQ < HOLD_FULL)) |=> errPulse); // R8

  AST_HOLD_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (holdCntQ != '0) && (holdCntQ <= HOLD_FULL)); // R8

endmodule

// File: rtl/cke_state_ctrl.sv
module cke_state_ctrl
  import cke_track_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cmdIn,
  input  logic        bankOpen,
  input  ckeEdge_t    edgeInfo,
  output pwrState_t   stateQ,
  output ctrlStrobe_t strobe
);

  pwrState_t nextState;
  logic      illegal;
  logic      idleCmd;

  assign idleCmd = (cmdIn == CMD_DESELECT) || (cmdIn == CMD_NOP);

  always_comb begin
    nextState = stateQ;
    illegal   = 1'b0;
    if (stateQ == PWR_NORMAL) begin
      unique case ({edgeInfo.prevLvl, edgeInfo.curLvl})
        2'b11: ;
        2'b10: begin
          if (idleCmd) begin
            nextState = bankOpen ? PWR_ACT_DOWN : PWR_PRE_DOWN;
          end else if ((cmdIn == CMD_REFRESH) && !bankOpen) begin
            nextState = PWR_SELF_REF;
          end else begin
            illegal = 1'b1;
          end
        end
        default: illegal = 1'b1;
      endcase
    end else begin
      unique case ({edgeInfo.prevLvl, edgeInfo.curLvl})
        2'b00: ;
        2'b01: begin
          if (idleCmd) nextState = PWR_NORMAL;
          else         illegal   = 1'b1;
        end
        default: illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= PWR_NORMAL;
    else     stateQ <= nextState;
  end

  assign strobe.raiseErr = illegal | edgeInfo.holdShort;

  AST_STAY_LOW_POWER: assert property (@(posedge clk) disable iff (rst)
    ((stateQ != PWR_NORMAL) && !edgeInfo.prevLvl && !edgeInfo.curLvl) |=> $stable(stateQ)); // R2

  AST_EXIT_LOW_POWER: assert property (@(posedge clk) disable iff (rst)
    ((stateQ != PWR_NORMAL) && !edgeInfo.prevLvl && edgeInfo.curLvl && idleCmd)
      |=> (stateQ == PWR_NORMAL)); // R3

  AST_ENTER_ACT_DOWN: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == PWR_NORMAL) && edgeInfo.prevLvl && !edgeInfo.curLvl && idleCmd && bankOpen)
      |=> (stateQ == PWR_ACT_DOWN)); // R4

  AST_ENTER_PRE_DOWN: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == PWR_NORMAL) && edgeInfo.prevLvl && !edgeInfo.curLvl && idleCmd && !bankOpen)
      |=> (stateQ == PWR_PRE_DOWN)); // R5

  AST_ENTER_SELF_REF: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == PWR_NORMAL) && edgeInfo.prevLvl && !edgeInfo.curLvl
      && (cmdIn == CMD_REFRESH) && !bankOpen) |=> (stateQ == PWR_SELF_REF)); // R6

  AST_BAD_FALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == PWR_NORMAL) && edgeInfo.prevLvl && !edgeInfo.curLvl && (cmdIn > CMD_REFRESH))
      |=> $stable(stateQ)); // R7

  AST_NORMAL_STEADY: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == PWR_NORMAL) && edgeInfo.prevLvl && edgeInfo.curLvl)
      |=> (stateQ == PWR_NORMAL)); // R9

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_track_pkg::*;
#(
  parameter int MIN_HOLD = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ckeIn,
  input  logic [2:0] cmdIn,
  input  logic       bankOpen,
  output logic [1:0] powerState,
  output logic       errPulse
);

  ckeEdge_t    edgeInfo;
  ctrlStrobe_t strobe;
  pwrState_t   stateQ;

  cke_edge_path #(.MIN_HOLD(MIN_HOLD)) u_path (
    .clk      (clk),
    .rst      (rst),
    .ckeIn    (ckeIn),
    .strobe   (strobe),
    .edgeInfo (edgeInfo),
    .errPulse (errPulse)
  );

  cke_state_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdIn    (cmdIn),
    .bankOpen (bankOpen),
    .edgeInfo (edgeInfo),
    .stateQ   (stateQ),
    .strobe   (strobe)
  );

  assign powerState = stateQ;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> ((powerState == 2'b00) && !errPulse)); // R1

endmodule

// File: tb/cke_power_tracker_bench.sv
module cke_power_tracker_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       ckeIn;
  logic [2:0] cmdIn;
  logic       bankOpen;
  logic [1:0] powerState;
  logic       errPulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cke_power_tracker #(.MIN_HOLD(3)) u_cke_power_tracker (
    .clk        (clk),
    .rst        (rst),
    .ckeIn      (ckeIn),
    .cmdIn      (cmdIn),
    .bankOpen   (bankOpen),
    .powerState (powerState),
    .errPulse   (errPulse)
  );

  localparam logic [1:0] ST_NORM = 2'b00;
  localparam logic [1:0] ST_ACT  = 2'b01;
  localparam logic [1:0] ST_PRE  = 2'b10;
  localparam logic [1:0] ST_SELF = 2'b11;

  task automatic step(input logic cke, input logic [2:0] cmd, input logic bank);
    ckeIn    = cke;
    cmdIn    = cmd;
    bankOpen = bank;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [1:0] expState, input logic expErr);
    checks++;
    if (powerState !== expState || errPulse !== expErr) begin
      errors++;
      $display("FAIL %s: state=%b err=%b, expected state=%b err=%b",
               tag, powerState, errPulse, expState, expErr);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    step(1'b1, 3'd1, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 reset state", ST_NORM, 1'b0);
  endtask

  task automatic t_normal_steady;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 3'(i + 2), i[0]);
      check("R9 steady high", ST_NORM, 1'b0);
    end
  endtask

  task automatic t_active_down;
    do_reset();
    step(1'b0, 3'd1, 1'b1);
    check("R4 active power-down entry", ST_ACT, 1'b0);
    step(1'b0, 3'd5, 1'b1);
    check("R2 hold active power-down", ST_ACT, 1'b0);
    step(1'b0, 3'd2, 1'b0);
    check("R2 hold with refresh cmd", ST_ACT, 1'b0);
    step(1'b1, 3'd0, 1'b1);
    check("R3 exit active power-down", ST_NORM, 1'b0);
  endtask

  task automatic t_precharge_down;
    do_reset();
    step(1'b0, 3'd0, 1'b0);
    check("R5 precharge power-down entry", ST_PRE, 1'b0);
    step(1'b0, 3'd3, 1'b0);
    step(1'b0, 3'd1, 1'b0);
    check("R2 hold precharge power-down", ST_PRE, 1'b0);
    step(1'b1, 3'd1, 1'b0);
    check("R3 exit precharge power-down", ST_NORM, 1'b0);
  endtask

  task automatic t_self_refresh;
    do_reset();
    step(1'b0, 3'd2, 1'b0);
    check("R6 self refresh entry", ST_SELF, 1'b0);
    step(1'b0, 3'd7, 1'b1);
    step(1'b0, 3'd4, 1'b0);
    check("R2 hold self refresh", ST_SELF, 1'b0);
    step(1'b1, 3'd0, 1'b0);
    check("R3 exit self refresh", ST_NORM, 1'b0);
  endtask

  task automatic t_illegal;
    do_reset();
    step(1'b0, 3'd4, 1'b0);
    check("R7 fall with other command", ST_NORM, 1'b1);
    do_reset();
    step(1'b0, 3'd2, 1'b1);
    check("R7 refresh with open bank", ST_NORM, 1'b1);
    do_reset();
    step(1'b0, 3'd1, 1'b0);
    step(1'b0, 3'd1, 1'b0);
    step(1'b0, 3'd1, 1'b0);
    step(1'b1, 3'd2, 1'b0);
    check("R7 rise with refresh in power-down", ST_PRE, 1'b1);
  endtask

  task automatic t_hold;
    do_reset();
    step(1'b0, 3'd1, 1'b1);
    check("R8 fall right after reset legal", ST_ACT, 1'b0);
    step(1'b1, 3'd1, 1'b1);
    check("R8 short hold flagged, exit applied", ST_NORM, 1'b1);
    step(1'b1, 3'd1, 1'b1);
    check("R10 error pulse one cycle", ST_NORM, 1'b0);
    step(1'b1, 3'd1, 1'b1);
    check("R10 no error on clean edge", ST_NORM, 1'b0);
    step(1'b0, 3'd0, 1'b0);
    check("R8 transition after exact minimum legal", ST_PRE, 1'b0);
  endtask

  initial begin
    rst      = 1'b1;
    ckeIn    = 1'b1;
    cmdIn    = 3'd1;
    bankOpen = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal_steady();
    t_active_down();
    t_precharge_down();
    t_self_refresh();
    t_illegal();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule